// File: doc/BRIEF.md
# Counter-Cell Sequential Data Tape

A small looped data memory whose storage cells are byte-wide up/down counters. Increment and decrement happen in place inside the addressed cell, so no separate arithmetic unit is needed. A head counter held inside the block picks the current cell. The head moves one step left or right, or it is loaded directly. It wraps at both ends of the tape.

Two three-bit control words drive the block, one for the cells and one for the head. Both use the same encoding: bit 2 is a load select, bit 1 is a count select and bit 0 is a one-cycle strobe. The select bits may be set up in any earlier cycle. Nothing changes until a rising clock edge sees the strobe high. The current cell is always visible on the outputs, both as a full byte and as a 7-bit character copy. The head address and every cell's contents are also brought out for display.

Top module: `counter_tape`

## Requirements
- R1: While rst_ni is low, every cell and the head address are cleared to zero.
- R2: A cell control of strobe=1, count=1, load=0 increments the selected cell by one modulo 256, so 255 becomes 0.
- R3: A cell control of strobe=1, count=1, load=1 decrements the selected cell by one modulo 256, so 0 becomes 255.
- R4: A cell control of strobe=1, count=0, load=1 writes data_i into the selected cell.
- R5: With strobe=0 on either control word, whatever the load and count bits are, no cell and no head state changes. With strobe=1 and load=count=0, nothing changes either.
- R6: Only the cell at the current head address is affected by a cell control. Every other cell keeps its value.
- R7: data_o always shows the selected cell, and ascii_o shows its low 7 bits.
- R8: A head control of strobe=1, count=1, load=0 moves the head up by one, and strobe=1, count=1, load=1 moves it down by one. The head wraps from NUM_CELLS-1 to 0 and from 0 to NUM_CELLS-1.
- R9: A head control of strobe=1, count=0, load=1 sets the head to data_i modulo NUM_CELLS.
- R10: When a cell action and a head action are strobed in the same cycle, the cell action applies to the cell selected before the head moves.
- R11: head_o is the head address zero-extended to 8 bits, and cells_o carries cell k in bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cell_ctl_i | input | 3 | Cell control {load, count, strobe} |
| head_ctl_i | input | 3 | Head control {load, count, strobe} |
| data_i | input | 8 | Load value for a cell or for the head |
| data_o | output | 8 | Value of the selected cell |
| ascii_o | output | 7 | Low 7 bits of the selected cell |
| head_o | output | 8 | Current head address |
| cells_o | output | 64 | Every cell's value, packed |

## Verification
The bench drives each cell value across both wrap points, 255 to 0 and 0 to 255. A counter with the wrong width or carry handling would stick at the limit or land on the wrong value there. It takes the head around both tape ends. An off-by-one wrap limit would either leave the head on a cell that does not exist or skip cell 0. It holds the load and count bits high with the strobe low, which catches a design that acts on level instead of on the strobe. It also strobes a cell action and a head move together, which shows whether the cell written is the old one or the new one. After every step the full packed cell vector is compared, so any write that leaks into a neighbouring cell is caught.

// File: rtl/tape_pkg.sv
package tape_pkg;
  typedef struct packed {
    logic load;
    logic count;
    logic strobe;
  } ctl_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_INC,
    OP_DEC,
    OP_LOAD
  } op_e;
endpackage

// File: rtl/tape_op_decode.sv
module tape_op_decode
  import tape_pkg::*;
(
  input  ctl_t ctl_i,
  output op_e  op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (ctl_i.strobe) begin
      case ({ctl_i.load, ctl_i.count})
        2'b01:   op_o = OP_INC;
        2'b11:   op_o = OP_DEC;
        2'b10:   op_o = OP_LOAD;
        default: op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tape_cell.sv
module tape_cell
  import tape_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (sel_i) begin
      case (op_i)
        OP_INC:  q_o <= q_o + DATA_W'(1);
        OP_DEC:  q_o <= q_o - DATA_W'(1);
        OP_LOAD: q_o <= data_i;
        default: q_o <= q_o;
      endcase
    end
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i || op_i == OP_NONE) |=> $stable(q_o));
  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && op_i == OP_INC) |=> q_o == $past(q_o) + DATA_W'(1));
  assert_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && op_i == OP_DEC) |=> q_o == $past(q_o) - DATA_W'(1));
  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && op_i == OP_LOAD) |=> q_o == $past(data_i));
endmodule

// File: rtl/tape_head.sv
module tape_head
  import tape_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HEAD_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [HEAD_W-1:0] head_o
);
  localparam logic [HEAD_W-1:0] LAST = HEAD_W'(NUM_CELLS - 1);

  logic [HEAD_W-1:0] load_val;
  assign load_val = HEAD_W'(32'(data_i) % NUM_CELLS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) head_o <= '0;
    else begin
      case (op_i)
        OP_INC:  head_o <= (head_o == LAST) ? '0 : head_o + HEAD_W'(1);
        OP_DEC:  head_o <= (head_o == '0) ? LAST : head_o - HEAD_W'(1);
        OP_LOAD: head_o <= load_val;
        default: head_o <= head_o;
      endcase
    end
  end

  assert_wrap_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC && head_o == LAST) |=> head_o == '0);
  assert_wrap_dn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DEC && head_o == '0) |=> head_o == LAST);
  assert_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(head_o) < NUM_CELLS);
  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NONE) |=> $stable(head_o));
endmodule

// File: rtl/counter_tape.sv
module counter_tape
  import tape_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned ASCII_W   = 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [2:0]                  cell_ctl_i,
  input  logic [2:0]                  head_ctl_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [DATA_W-1:0]           data_o,
  output logic [ASCII_W-1:0]          ascii_o,
  output logic [ADDR_W-1:0]           head_o,
  output logic [NUM_CELLS*DATA_W-1:0] cells_o
);
  localparam int unsigned HEAD_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;

  op_e               cell_op, head_op;
  logic [HEAD_W-1:0] head;
  logic [DATA_W-1:0] cell_q [NUM_CELLS];

  tape_op_decode u_cell_dec (.ctl_i(ctl_t'(cell_ctl_i)), .op_o(cell_op));
  tape_op_decode u_head_dec (.ctl_i(ctl_t'(head_ctl_i)), .op_o(head_op));

  tape_head #(.NUM_CELLS(NUM_CELLS), .DATA_W(DATA_W), .HEAD_W(HEAD_W)) u_head (
    .clk_i, .rst_ni, .op_i(head_op), .data_i, .head_o(head)
  );

  // cells see the pre-move head: both registers sample on the same edge
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    tape_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i, .rst_ni,
      .sel_i (head == HEAD_W'(i)),
      .op_i  (cell_op),
      .data_i,
      .q_o   (cell_q[i])
    );
    assign cells_o[i*DATA_W +: DATA_W] = cell_q[i];
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_CELLS; i++)
      if (head == HEAD_W'(i)) data_o = cell_q[i];
  end

  assign ascii_o = data_o[ASCII_W-1:0];
  assign head_o  = ADDR_W'(head);

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (cells_o == '0 && head_o == '0));
endmodule

// File: tb/sim_counter_tape.sv
`timescale 1ns/1ps
module sim_counter_tape;
  localparam int N = 8;
  localparam logic [2:0] C_NOP = 3'b000, C_INC = 3'b011, C_DEC = 3'b111,
                         C_LD  = 3'b101, C_EMPTY = 3'b001, C_SETUP = 3'b110;

  logic clk = 0, rst_n = 0;
  logic [2:0] cell_ctl = C_NOP, head_ctl = C_NOP;
  logic [7:0] din = 0, dout, hout;
  logic [6:0] aout;
  logic [N*8-1:0] cells;

  int tests = 0, fails = 0;
  logic [7:0] mc [N];
  int mh = 0;

  always #2.5 clk = ~clk;

  counter_tape u0 (.clk_i(clk), .rst_ni(rst_n), .cell_ctl_i(cell_ctl),
    .head_ctl_i(head_ctl), .data_i(din), .data_o(dout), .ascii_o(aout),
    .head_o(hout), .cells_o(cells));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    logic [N*8-1:0] ev;
    for (int k = 0; k < N; k++) ev[k*8 +: 8] = mc[k];
    chk({req, " data_o R7"}, 64'(dout), 64'(mc[mh]));
    chk({req, " ascii_o R7"}, 64'(aout), 64'(mc[mh][6:0]));
    chk({req, " head_o R11"}, 64'(hout), 64'(mh));
    chk({req, " cells_o R6 R11"}, 64'(cells), 64'(ev));
  endtask

  // one strobed cycle, then update the model and compare
  task automatic step(logic [2:0] cc, logic [2:0] hc, logic [7:0] d);
    @(negedge clk);
    cell_ctl = cc; head_ctl = hc; din = d;
    @(negedge clk);
    cell_ctl = C_NOP; head_ctl = C_NOP;
    case (cc)
      C_INC: mc[mh] = mc[mh] + 8'd1;
      C_DEC: mc[mh] = mc[mh] - 8'd1;
      C_LD:  mc[mh] = d;
      default: ;
    endcase
    case (hc)
      C_INC: mh = (mh + 1) % N;
      C_DEC: mh = (mh + N - 1) % N;
      C_LD:  mh = int'(d) % N;
      default: ;
    endcase
  endtask

  task automatic t_reset_r1;
    for (int k = 0; k < N; k++) mc[k] = 0;
    mh = 0;
    #1; check_state("R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); check_state("R1 after reset");
  endtask

  task automatic t_inc_r2;
    repeat (3) step(C_INC, C_NOP, 8'h00);
    check_state("R2 inc");
    step(C_LD, C_NOP, 8'hFF);
    step(C_INC, C_NOP, 8'h00);
    chk("R2 wrap 255->0", 64'(dout), 64'h0);
    check_state("R2 wrap");
  endtask

  task automatic t_dec_r3;
    step(C_DEC, C_NOP, 8'h00);
    chk("R3 wrap 0->255", 64'(dout), 64'hFF);
    chk("R3 ascii 7F R7", 64'(aout), 64'h7F);
    step(C_DEC, C_NOP, 8'h00);
    check_state("R3 dec");
  endtask

  task automatic t_load_r4;
    step(C_LD, C_NOP, 8'hA5);
    chk("R4 load", 64'(dout), 64'hA5);
    chk("R4 ascii R7", 64'(aout), 64'h25);
    check_state("R4");
  endtask

  task automatic t_no_strobe_r5;
    @(negedge clk);
    cell_ctl = C_SETUP; head_ctl = C_SETUP; din = 8'h3C;
    repeat (2) @(negedge clk);
    cell_ctl = 3'b010; head_ctl = 3'b100;
    @(negedge clk);
    check_state("R5 no strobe");
    step(C_EMPTY, C_EMPTY, 8'h77);
    check_state("R5 empty strobe");
  endtask

  task automatic t_head_r8;
    step(C_NOP, C_INC, 8'h00);
    chk("R8 right", 64'(hout), 64'd1);
    step(C_LD, C_NOP, 8'h11);
    for (int k = 0; k < N - 1; k++) step(C_NOP, C_INC, 8'h00);
    chk("R8 wrap up", 64'(hout), 64'd0);
    step(C_NOP, C_DEC, 8'h00);
    chk("R8 wrap down", 64'(hout), 64'(N - 1));
    step(C_INC, C_NOP, 8'h00);
    check_state("R8 R6 far cell");
  endtask

  task automatic t_head_load_r9;
    step(C_NOP, C_LD, 8'd13);
    chk("R9 head load mod", 64'(hout), 64'd5);
    step(C_LD, C_NOP, 8'h42);
    check_state("R9");
  endtask

  task automatic t_same_cycle_r10;
    step(C_INC, C_INC, 8'h00);
    chk("R10 old cell written", 64'(cells[5*8 +: 8]), 64'h43);
    chk("R10 new cell untouched", 64'(dout), 64'(mc[6]));
    step(C_LD, C_DEC, 8'h99);
    chk("R10 load before move", 64'(cells[6*8 +: 8]), 64'h99);
    check_state("R10");
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_inc_r2();
    t_dec_r3();
    t_load_r4();
    t_no_strobe_r5();
    t_head_r8();
    t_head_load_r9();
    t_same_cycle_r10();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule